// File: doc/BRIEF.md
# Fractional-Rate Nanosecond Time-of-Day Counter

This block keeps a free-running 44-bit nanosecond time for precision time protocol work. On every clock it adds a programmable fixed-point increment to the count. The increment has 3 integer bits and 29 fractional bits. A 29-bit fraction accumulator holds the sub-nanosecond remainder. When that fraction carries, the count takes one extra nanosecond. The reset increment is 4.0 ns per cycle, which matches a 250 MHz counting clock. Software trims the rate by nudging the increment slightly above or below that value. Writing an increment of zero stops time.

Software reaches the block through a small single-cycle register port with four word registers:

| Offset | Contents |
|---|---|
| 0x00 | nanosecond bits 3..0 |
| 0x04 | nanosecond bits 35..4 |
| 0x08 | nanosecond bits 43..36 |
| 0x0C | increment |

To load the time, software writes the low field, then the middle field, then the upper field. The upper field is read back in the bottom byte of the data word but written from the second byte. A saved value must therefore be shifted up by eight bits before it is restored. The full count is also presented on a registered output for local consumers.

Top module: `ptp_tod_counter`

## Requirements
- R1: A synchronous reset sets the count to zero, the fraction to zero, the increment to 0x80000000 and the read data to zero; these values are visible on the edge after reset is sampled.
- R2: With the increment at 0x80000000 and no time-field write, the count advances by exactly 4 per clock.
- R3: On a clock with no time-field write, the count advances by the increment bits [31:29] plus the carry out of adding increment bits [28:0] to the 29-bit fraction. For example, an increment of 0x30000000 (1.5 ns) gives steps alternating between 1 and 2 once the fraction starts from zero.
- R4: While the increment is zero, the count holds its value. After a non-zero increment is written, counting resumes from the held value.
- R5: A write to offset 0x00 replaces count bits [3:0] with write-data bits [3:0] and clears the fraction. Count bits [43:4] keep their value, and the count does not advance on that clock.
- R6: A write to offset 0x04 replaces count bits [35:4] with write data [31:0]. A write to offset 0x08 replaces count bits [43:36] with write data [15:8] and ignores all other write-data bits. On either write, the other count bits hold and the count does not advance.
- R7: A read returns, one clock after the request, the value as it stood on the request clock, with unused bits zero:
  - offset 0x00 gives count [3:0] in bits [3:0];
  - offset 0x04 gives count [35:4];
  - offset 0x08 gives count [43:36] in bits [7:0];
  - offset 0x0C gives the increment.
- R8: The count is modulo 2^44. Stepping 4 from 0xFFFFFFFFFFF yields 3.
- R9: An increment write is used from the following clock on. The clock of the write itself still steps with the old increment.
- R10: Bus cycles with select low, including ones with write enable high, change neither the count nor the increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting and bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request this clock |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset; bits [3:2] pick the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the clock after a read |
| time_ns | output | 44 | Current nanosecond count |

## Verification
The hardest state to reach from the ports is the wrap at 2^44. A free-running count would need hours to get there. The bench first freezes time with a zero increment, then loads all-ones through the three field writes, then restores the nominal increment. This makes the wrap happen on a known clock.

The fraction-clear on a low-field write is only visible when the fraction is non-zero. So the bench runs a 1.5 ns increment and waits until its own model shows a half-nanosecond remainder. Only then does it write the low field and check the next step size.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;
  localparam int TOD_NS_W    = 44;
  localparam int TOD_LOW_W   = 4;
  localparam int TOD_MID_W   = 32;
  localparam int TOD_UP_W    = 8;
  localparam int TOD_DATA_W  = 32;
  localparam int TOD_FRAC_W  = 29;
  localparam int TOD_UP_LANE = 8;
  localparam logic [31:0] TOD_INC_RESET = 32'h8000_0000;

  typedef enum logic [1:0] {
    FLD_LOW = 2'd0,
    FLD_MID = 2'd1,
    FLD_UP  = 2'd2,
    FLD_INC = 2'd3
  } tod_field_e;
endpackage

// File: rtl/tod_regport.sv
module tod_regport
  import ptp_tod_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = TOD_DATA_W,
  parameter int NS_W    = TOD_NS_W,
  parameter int LOW_W   = TOD_LOW_W,
  parameter int MID_W   = TOD_MID_W,
  parameter int UP_W    = TOD_UP_W,
  parameter int INC_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NS_W-1:0]   time_ns,
  input  logic [INC_W-1:0]  inc_q,
  output logic [3:0]        wr_vec,
  output logic [DATA_W-1:0] rdata
);
  localparam int NFIELD = 4;

  tod_field_e fld;
  assign fld = tod_field_e'(addr[3:2]);

  // one write strobe per register
  for (genvar g = 0; g < NFIELD; g++) begin : g_wstb
    assign wr_vec[g] = sel && we && (addr[3:2] == 2'(g));
  end

  logic [DATA_W-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    unique case (fld)
      FLD_LOW: rd_next[LOW_W-1:0] = time_ns[LOW_W-1:0];
      FLD_MID: rd_next[MID_W-1:0] = time_ns[LOW_W +: MID_W];
      FLD_UP:  rd_next[UP_W-1:0]  = time_ns[LOW_W+MID_W +: UP_W];
      FLD_INC: rd_next[INC_W-1:0] = inc_q;
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (sel && !we)
      rdata <= rd_next;
  end
endmodule

// File: rtl/tod_rate_accum.sv
module tod_rate_accum
  import ptp_tod_pkg::*;
#(
  parameter int INC_W = 32,
  parameter int FRAC_W = TOD_FRAC_W,
  parameter logic [INC_W-1:0] INC_RESET = TOD_INC_RESET,
  localparam int INT_W = INC_W - FRAC_W,
  localparam int STEP_W = INT_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc_wr,
  input  logic [INC_W-1:0]  inc_wdata,
  input  logic              frac_clr,
  input  logic              hold,
  output logic [INC_W-1:0]  inc_q,
  output logic [STEP_W-1:0] step
);
  logic [FRAC_W-1:0] frac_q;
  logic [FRAC_W:0]   frac_sum;

  assign frac_sum = {1'b0, frac_q} + {1'b0, inc_q[FRAC_W-1:0]};
  assign step = {1'b0, inc_q[INC_W-1:FRAC_W]} + STEP_W'(frac_sum[FRAC_W]);

  always_ff @(posedge clk) begin
    if (rst) begin
      inc_q  <= INC_RESET;
      frac_q <= '0;
    end else begin
      if (inc_wr)
        inc_q <= inc_wdata;
      if (frac_clr)
        frac_q <= '0;
      else if (!hold)
        frac_q <= frac_sum[FRAC_W-1:0];
    end
  end
endmodule

// File: rtl/tod_ns_core.sv
module tod_ns_core
  import ptp_tod_pkg::*;
#(
  parameter int NS_W    = TOD_NS_W,
  parameter int LOW_W   = TOD_LOW_W,
  parameter int MID_W   = TOD_MID_W,
  parameter int UP_W    = TOD_UP_W,
  parameter int DATA_W  = TOD_DATA_W,
  parameter int UP_LANE = TOD_UP_LANE,
  parameter int STEP_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_low,
  input  logic              wr_mid,
  input  logic              wr_up,
  input  logic [DATA_W-1:0] wdata,
  input  logic [STEP_W-1:0] step,
  output logic [NS_W-1:0]   time_ns
);
  localparam int MID_LSB = LOW_W;
  localparam int UP_LSB  = LOW_W + MID_W;

  logic [NS_W-1:0] ns_next;

  always_comb begin
    ns_next = time_ns;
    if (wr_low || wr_mid || wr_up) begin
      if (wr_low) ns_next[LOW_W-1:0]      = wdata[LOW_W-1:0];
      if (wr_mid) ns_next[MID_LSB +: MID_W] = wdata[MID_W-1:0];
      if (wr_up)  ns_next[UP_LSB +: UP_W]   = wdata[UP_LANE +: UP_W];
    end else begin
      ns_next = time_ns + NS_W'(step);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      time_ns <= '0;
    else
      time_ns <= ns_next;
  end
endmodule

// File: rtl/ptp_tod_counter.sv
module ptp_tod_counter
  import ptp_tod_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = TOD_DATA_W,
  parameter int NS_W    = TOD_NS_W,
  parameter int LOW_W   = TOD_LOW_W,
  parameter int MID_W   = TOD_MID_W,
  parameter int UP_W    = TOD_UP_W,
  parameter int FRAC_W  = TOD_FRAC_W,
  parameter int UP_LANE = TOD_UP_LANE,
  parameter logic [DATA_W-1:0] INC_RESET = TOD_INC_RESET,
  localparam int STEP_W = DATA_W - FRAC_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NS_W-1:0]   time_ns
);
  logic [3:0]        wr_vec;
  logic [DATA_W-1:0] inc_q;
  logic [STEP_W-1:0] step;
  logic              time_wr;

  assign time_wr = wr_vec[FLD_LOW] | wr_vec[FLD_MID] | wr_vec[FLD_UP];

  tod_regport #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NS_W(NS_W), .LOW_W(LOW_W),
    .MID_W(MID_W), .UP_W(UP_W), .INC_W(DATA_W)
  ) regport_i (
    .clk(clk), .rst(rst), .sel(bus_sel), .we(bus_we), .addr(bus_addr),
    .time_ns(time_ns), .inc_q(inc_q), .wr_vec(wr_vec), .rdata(bus_rdata)
  );

  tod_rate_accum #(
    .INC_W(DATA_W), .FRAC_W(FRAC_W), .INC_RESET(INC_RESET)
  ) accum_i (
    .clk(clk), .rst(rst), .inc_wr(wr_vec[FLD_INC]), .inc_wdata(bus_wdata),
    .frac_clr(wr_vec[FLD_LOW]), .hold(time_wr), .inc_q(inc_q), .step(step)
  );

  tod_ns_core #(
    .NS_W(NS_W), .LOW_W(LOW_W), .MID_W(MID_W), .UP_W(UP_W),
    .DATA_W(DATA_W), .UP_LANE(UP_LANE), .STEP_W(STEP_W)
  ) core_i (
    .clk(clk), .rst(rst), .wr_low(wr_vec[FLD_LOW]), .wr_mid(wr_vec[FLD_MID]),
    .wr_up(wr_vec[FLD_UP]), .wdata(bus_wdata), .step(step), .time_ns(time_ns)
  );
endmodule

// File: rtl/ptp_tod_checker.sv
module ptp_tod_checker #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int NS_W   = 44,
  parameter int LOW_W  = 4,
  parameter int FRAC_W = 29,
  parameter int UP_LANE = 8,
  parameter logic [DATA_W-1:0] INC_RESET = 32'h8000_0000
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NS_W-1:0]   time_ns,
  input logic [DATA_W-1:0] inc_q
);
  logic tw, low_w, up_w, inc_rd;
  assign tw     = bus_sel && bus_we && (bus_addr[3:2] != 2'd3);
  assign low_w  = bus_sel && bus_we && (bus_addr[3:2] == 2'd0);
  assign up_w   = bus_sel && bus_we && (bus_addr[3:2] == 2'd2);
  assign inc_rd = bus_sel && !bus_we && (bus_addr[3:2] == 2'd3);

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (time_ns == '0 && inc_q == INC_RESET && bus_rdata == '0));

  assert_step_bounds_R3: assert property (@(posedge clk) disable iff (rst)
    (!tw && inc_q != '0) |=>
      ((NS_W'(time_ns - $past(time_ns)) == NS_W'($past(inc_q) >> FRAC_W)) ||
       (NS_W'(time_ns - $past(time_ns)) == NS_W'(($past(inc_q) >> FRAC_W) + 1))));

  assert_freeze_R4: assert property (@(posedge clk) disable iff (rst)
    (!tw && inc_q == '0) |=> $stable(time_ns));

  assert_low_write_R5: assert property (@(posedge clk) disable iff (rst)
    low_w |=> (time_ns[LOW_W-1:0] == $past(bus_wdata[LOW_W-1:0]) &&
               time_ns[NS_W-1:LOW_W] == $past(time_ns[NS_W-1:LOW_W])));

  assert_up_lane_R6: assert property (@(posedge clk) disable iff (rst)
    up_w |=> (time_ns[NS_W-1 -: 8] == $past(bus_wdata[UP_LANE +: 8])));

  assert_inc_read_R7: assert property (@(posedge clk) disable iff (rst)
    inc_rd |=> (bus_rdata == $past(inc_q)));

  assert_idle_bus_R10: assert property (@(posedge clk) disable iff (rst)
    (!bus_sel) |=> $stable(inc_q));
endmodule

bind ptp_tod_counter ptp_tod_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NS_W(NS_W), .LOW_W(LOW_W),
  .FRAC_W(FRAC_W), .UP_LANE(UP_LANE), .INC_RESET(INC_RESET)
) checker_i (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .time_ns(time_ns), .inc_q(inc_q)
);

// File: tb/ptp_tod_counter_tb_top.sv
module ptp_tod_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [43:0] time_ns;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  string phase = "R1";

  always #2 clk = ~clk;

  ptp_tod_counter dut_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .time_ns(time_ns)
  );

  // behavioural reference model
  logic [43:0]    m_ns;
  longint         m_frac;
  logic [31:0]    m_inc;
  logic [31:0]    m_rd;
  localparam longint FMOD = 64'd1 << 29;

  always @(posedge clk) begin
    longint sum;
    if (rst) begin
      m_ns <= '0; m_frac <= 0; m_inc <= 32'h8000_0000; m_rd <= '0;
    end else begin
      if (bus_sel && !bus_we) begin
        case (bus_addr[3:2])
          2'd0: m_rd <= {28'd0, m_ns[3:0]};
          2'd1: m_rd <= m_ns[35:4];
          2'd2: m_rd <= {24'd0, m_ns[43:36]};
          default: m_rd <= m_inc;
        endcase
      end
      if (bus_sel && bus_we && bus_addr[3:2] == 2'd0) begin
        m_ns[3:0] <= bus_wdata[3:0]; m_frac <= 0;
      end else if (bus_sel && bus_we && bus_addr[3:2] == 2'd1) begin
        m_ns[35:4] <= bus_wdata;
      end else if (bus_sel && bus_we && bus_addr[3:2] == 2'd2) begin
        m_ns[43:36] <= bus_wdata[15:8];
      end else begin
        sum = m_frac + longint'(m_inc % 32'h2000_0000);
        m_frac <= sum % FMOD;
        m_ns <= m_ns + 44'(longint'(m_inc >> 29) + sum / FMOD);
      end
      if (bus_sel && bus_we && bus_addr[3:2] == 2'd3) m_inc <= bus_wdata;
    end
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst && cycles > 1) begin
      check({phase, " time"}, 64'(time_ns), 64'(m_ns));
      check({phase, " rdata"}, 64'(bus_rdata), 64'(m_rd));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      fails++; tests++;
      $display("FAIL watchdog: actual %0d expected <= 50000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 0; bus_addr = a;
    @(negedge clk); bus_sel = 0; d = bus_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [43:0] t0;
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    check("R1 reset count", 64'(time_ns), 0);
    check("R1 reset rdata", 64'(bus_rdata), 0);
    rd(4'hC, d);
    check("R1 reset increment R7", 64'(d), 64'h8000_0000);

    phase = "R2";
    t0 = time_ns; idle(10);
    check("R2 nominal rate", 64'(time_ns), 64'(t0 + 44'd40));

    phase = "R9";
    @(negedge clk); t0 = time_ns;
    bus_sel = 1; bus_we = 1; bus_addr = 4'hC; bus_wdata = 32'h3000_0000;
    @(negedge clk); bus_sel = 0; bus_we = 0;
    check("R9 old increment on write clock", 64'(time_ns), 64'(t0 + 44'd4));
    phase = "R3";
    t0 = time_ns; idle(4);
    check("R3 fractional 1.5ns steps", 64'(time_ns), 64'(t0 + 44'd6));

    phase = "R5";
    while (m_frac == 0) @(negedge clk);
    t0 = time_ns;
    bus_sel = 1; bus_we = 1; bus_addr = 4'h0; bus_wdata = 32'hFFFF_FFF9;
    @(negedge clk); bus_sel = 0; bus_we = 0;
    check("R5 low write", 64'(time_ns), 64'({t0[43:4], 4'h9}));
    @(negedge clk);
    check("R5 fraction cleared", 64'(time_ns), 64'({t0[43:4], 4'h9} + 44'd1));

    phase = "R4";
    wr(4'hC, 32'h0);
    t0 = time_ns; idle(6);
    check("R4 frozen", 64'(time_ns), 64'(t0));

    phase = "R6";
    wr(4'h0, 32'h5);
    wr(4'h4, 32'h1234_5678);
    wr(4'h8, 32'h5A5A_AB77);
    check("R6 field load", 64'(time_ns), 64'(44'hAB_1234_5678_5));

    phase = "R7";
    rd(4'h0, d); check("R7 low read", 64'(d), 64'h5);
    rd(4'h4, d); check("R7 mid read", 64'(d), 64'h1234_5678);
    rd(4'h8, d); check("R7 upper read", 64'(d), 64'hAB);

    phase = "R10";
    @(negedge clk); bus_sel = 0; bus_we = 1; bus_addr = 4'hC; bus_wdata = 32'hFFFF_FFFF;
    @(negedge clk); bus_addr = 4'h4;
    @(negedge clk); bus_we = 0;
    check("R10 deselected write", 64'(time_ns), 64'(44'hAB_1234_5678_5));
    rd(4'hC, d); check("R10 increment untouched", 64'(d), 0);

    phase = "R4";
    wr(4'hC, 32'h8000_0000);
    @(negedge clk);
    check("R4 resume", 64'(time_ns), 64'(44'hAB_1234_5678_5 + 44'd4));

    phase = "R8";
    wr(4'hC, 32'h0);
    wr(4'h0, 32'hF);
    wr(4'h4, 32'hFFFF_FFFF);
    wr(4'h8, 32'h0000_FF00);
    check("R8 loaded max", 64'(time_ns), 64'hFFF_FFFF_FFFF);
    wr(4'hC, 32'h8000_0000);
    check("R8 held on inc write", 64'(time_ns), 64'hFFF_FFFF_FFFF);
    @(negedge clk);
    check("R8 wrap", 64'(time_ns), 64'h3);
    idle(3);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule